// File: doc/BRIEF.md
# Block-Parallel Three-Tap FIR Filter

This block is a three-tap finite impulse response filter that consumes a block of `LANES` signed samples on every valid clock and produces a block of the same size. Each lane has its own multipliers and adders. The filter therefore handles `LANES` samples per clock, and its effective sample rate is `LANES` times the clock rate. Lane k of an input block carries sample x(LANES·m + k), and lane k of the output block carries y(LANES·m + k). The two newest samples of each block are kept in registers, because the first lanes of the next block need them as their older taps.

The three signed coefficients are written through a write-enable port. A build-time switch `PIPE` adds two register cuts inside every lane: one after the multipliers and one after the first adder. Without the cuts, the critical path is one multiply followed by two adds. With the cuts, the longest stage is a single multiply. The output valid flag is delayed by the same number of cycles as the data.

Products are kept at full width. The sums carry two guard bits, and the final sum is cut to the output width by keeping its most significant bits.

Top module: `fir_par_top`

## Requirements
- R1: Output lane k of a block equals ca·x(n) + cb·x(n−1) + cc·x(n−2) for n = LANES·m + k. Sample lane k occupies `in_data[k*DW +: DW]` and result lane k occupies `out_data[k*OW +: OW]`. All values are two's complement.
- R2: Lanes 0 and 1 take their older taps from the last two samples of the previous valid block. Lane 0 uses lanes LANES−1 and LANES−2 of that block, and lane 1 uses lane LANES−1 of that block.
- R3: Cycles with `in_valid` low do not alter the sample history. The block after an idle gap continues the sequence from the last valid block.
- R4: While reset is low, `out_valid` and `out_data` are zero. The first block after reset is computed as if all earlier samples were zero.
- R5: `out_valid` is high exactly 3 cycles after a cycle with `in_valid` high when `PIPE`=1, and exactly 1 cycle after when `PIPE`=0. Every valid input block yields exactly one valid output block.
- R6: A coefficient write (`coef_we` high) applies from the next valid block onward. A block presented in the same cycle as the write still uses the old coefficients.
- R7: The output lane is the full-precision sum arithmetically shifted right by (DW+CW+2−OW) bits. The result is floored: a sum of −1 gives all ones.
- R8: While `out_valid` is low, `out_data` holds its last value.
- R9: When all three coefficients in effect are zero, every output lane of that block is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input block valid |
| in_data | input | LANES*DW | Packed signed input samples, lane 0 in the low bits |
| coef_we | input | 1 | Coefficient write enable |
| coef_a | input | CW | Signed coefficient for the current sample |
| coef_b | input | CW | Signed coefficient for the previous sample |
| coef_c | input | CW | Signed coefficient for the sample two back |
| out_valid | output | 1 | Output block valid |
| out_data | output | LANES*OW | Packed signed output samples, lane 0 in the low bits |

## Verification
The hardest case to reach is a coefficient write landing in the same cycle as a valid block. That block must still use the old coefficients while its history is still updated, and only the following block may see the new set. The bench drives that exact cycle with a shared-edge task, then sends a second block directly behind it. It also inserts idle gaps between blocks, so history that crosses a gap is compared against a model that only advances on valid blocks. Extreme negative samples and a sum of −1 exercise the floored truncation.

// File: rtl/fir_par_pkg.sv
package fir_par_pkg;
    localparam int unsigned GUARD_BITS = 2;

    function automatic int latency(input bit pipe);
        return pipe ? 3 : 1;
    endfunction
endpackage

// File: rtl/fir_par_history.sv
module fir_par_history #(
    parameter int LANES = 3,
    parameter int DW    = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic [LANES*DW-1:0]    in_data,
    output logic signed [DW-1:0]   prev1,
    output logic signed [DW-1:0]   prev2
);
    typedef struct packed {
        logic [DW-1:0] h1;
        logic [DW-1:0] h2;
    } hist_t;

    hist_t hist_d, hist_q;

    always_comb begin
        hist_d = hist_q;
        if (in_valid) begin
            hist_d.h1 = in_data[(LANES-1)*DW +: DW];
            hist_d.h2 = in_data[(LANES-2)*DW +: DW];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) hist_q <= '0;
        else        hist_q <= hist_d;
    end

    assign prev1 = hist_q.h1;
    assign prev2 = hist_q.h2;
endmodule

// File: rtl/fir_par_lane.sv
module fir_par_lane
    import fir_par_pkg::*;
#(
    parameter int DW   = 8,
    parameter int CW   = 8,
    parameter int OW   = 12,
    parameter bit PIPE = 1'b1
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 vld_in,
    input  logic signed [DW-1:0] x0,
    input  logic signed [DW-1:0] x1,
    input  logic signed [DW-1:0] x2,
    input  logic signed [CW-1:0] ca,
    input  logic signed [CW-1:0] cb,
    input  logic signed [CW-1:0] cc,
    output logic signed [OW-1:0] y,
    output logic                 y_valid
);
    localparam int PW = DW + CW;
    localparam int SW = PW + GUARD_BITS;

    logic signed [PW-1:0] m0, m1, m2;
    assign m0 = x0 * ca;
    assign m1 = x1 * cb;
    assign m2 = x2 * cc;

    function automatic logic signed [SW-1:0] widen(input logic signed [PW-1:0] v);
        return {{GUARD_BITS{v[PW-1]}}, v};
    endfunction

    function automatic logic signed [OW-1:0] narrow(input logic signed [SW-1:0] v);
        return v[SW-1 -: OW];
    endfunction

    generate
        if (PIPE) begin : g_pipe
            typedef struct packed {
                logic          v1;
                logic [PW-1:0] p0;
                logic [PW-1:0] p1;
                logic [PW-1:0] p2;
                logic          v2;
                logic [SW-1:0] s01;
                logic [SW-1:0] s2;
                logic          v3;
                logic [OW-1:0] y;
            } st_t;

            st_t st_d, st_q;

            always_comb begin
                st_d    = st_q;
                st_d.v1 = vld_in;
                if (vld_in) begin
                    st_d.p0 = m0;
                    st_d.p1 = m1;
                    st_d.p2 = m2;
                end
                st_d.v2 = st_q.v1;
                if (st_q.v1) begin
                    st_d.s01 = widen(st_q.p0) + widen(st_q.p1);
                    st_d.s2  = widen(st_q.p2);
                end
                st_d.v3 = st_q.v2;
                if (st_q.v2) begin
                    st_d.y = narrow(st_q.s01 + st_q.s2);
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign y       = st_q.y;
            assign y_valid = st_q.v3;
        end else begin : g_flat
            typedef struct packed {
                logic          v;
                logic [OW-1:0] y;
            } st_t;

            st_t st_d, st_q;

            always_comb begin
                st_d   = st_q;
                st_d.v = vld_in;
                if (vld_in) begin
                    st_d.y = narrow(widen(m0) + widen(m1) + widen(m2));
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) st_q <= '0;
                else        st_q <= st_d;
            end

            assign y       = st_q.y;
            assign y_valid = st_q.v;
        end
    endgenerate
endmodule

// File: rtl/fir_par_top.sv
module fir_par_top
    import fir_par_pkg::*;
#(
    parameter int LANES = 3,
    parameter int DW    = 8,
    parameter int CW    = 8,
    parameter int OW    = 12,
    parameter bit PIPE  = 1'b1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  in_valid,
    input  logic [LANES*DW-1:0]   in_data,
    input  logic                  coef_we,
    input  logic [CW-1:0]         coef_a,
    input  logic [CW-1:0]         coef_b,
    input  logic [CW-1:0]         coef_c,
    output logic                  out_valid,
    output logic [LANES*OW-1:0]   out_data
);
    typedef struct packed {
        logic [CW-1:0] a;
        logic [CW-1:0] b;
        logic [CW-1:0] c;
    } coef_t;

    coef_t coef_d, coef_q;

    always_comb begin
        coef_d = coef_q;
        if (coef_we) begin
            coef_d.a = coef_a;
            coef_d.b = coef_b;
            coef_d.c = coef_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) coef_q <= '0;
        else        coef_q <= coef_d;
    end

    logic signed [DW-1:0] prev1, prev2;

    fir_par_history #(.LANES(LANES), .DW(DW)) u_hist (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (in_valid),
        .in_data  (in_data),
        .prev1    (prev1),
        .prev2    (prev2)
    );

    logic [LANES-1:0] lane_vld;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        logic signed [DW-1:0] t0, t1, t2;
        logic signed [OW-1:0] y_k;

        assign t0 = in_data[k*DW +: DW];
        if (k == 0) begin : g_first
            assign t1 = prev1;
            assign t2 = prev2;
        end else if (k == 1) begin : g_second
            assign t1 = in_data[0 +: DW];
            assign t2 = prev1;
        end else begin : g_rest
            assign t1 = in_data[(k-1)*DW +: DW];
            assign t2 = in_data[(k-2)*DW +: DW];
        end

        fir_par_lane #(.DW(DW), .CW(CW), .OW(OW), .PIPE(PIPE)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .vld_in  (in_valid),
            .x0      (t0),
            .x1      (t1),
            .x2      (t2),
            .ca      (coef_q.a),
            .cb      (coef_q.b),
            .cc      (coef_q.c),
            .y       (y_k),
            .y_valid (lane_vld[k])
        );

        assign out_data[k*OW +: OW] = y_k;
    end

    assign out_valid = &lane_vld;
endmodule

// File: rtl/fir_par_chk.sv
module fir_par_chk
    import fir_par_pkg::*;
#(
    parameter int LANES = 3,
    parameter int CW    = 8,
    parameter int OW    = 12,
    parameter bit PIPE  = 1'b1
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic                 in_valid,
    input logic                 coef_we,
    input logic [CW-1:0]        coef_a,
    input logic [CW-1:0]        coef_b,
    input logic [CW-1:0]        coef_c,
    input logic                 out_valid,
    input logic [LANES*OW-1:0]  out_data
);
    localparam int LAT = latency(PIPE);

    logic [LAT-1:0] vpipe, zpipe;
    logic [CW-1:0]  sh_a, sh_b, sh_c;
    logic           zero_now;

    assign zero_now = in_valid && (sh_a == '0) && (sh_b == '0) && (sh_c == '0);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vpipe <= '0;
            zpipe <= '0;
            sh_a  <= '0;
            sh_b  <= '0;
            sh_c  <= '0;
        end else begin
            vpipe <= (vpipe << 1) | LAT'(in_valid);
            zpipe <= (zpipe << 1) | LAT'(zero_now);
            if (coef_we) begin
                sh_a <= coef_a;
                sh_b <= coef_b;
                sh_c <= coef_c;
            end
        end
    end

    // R5
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == vpipe[LAT-1]);

    // R8
    hold_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid |-> $stable(out_data));

    // R4
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R9
    zero_coef_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && zpipe[LAT-1]) |-> (out_data == '0));
endmodule

bind fir_par_top fir_par_chk #(.LANES(LANES), .CW(CW), .OW(OW), .PIPE(PIPE)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .coef_we   (coef_we),
    .coef_a    (coef_a),
    .coef_b    (coef_b),
    .coef_c    (coef_c),
    .out_valid (out_valid),
    .out_data  (out_data)
);

// File: tb/fir_par_top_tb.sv
module fir_par_top_tb;
    localparam int LANES = 3;
    localparam int DW    = 8;
    localparam int CW    = 8;
    localparam int OW    = 12;
    localparam bit PIPE  = 1'b1;
    localparam int LAT   = PIPE ? 3 : 1;
    localparam int SHIFT = DW + CW + 2 - OW;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  in_valid = 1'b0;
    logic [LANES*DW-1:0]   in_data = '0;
    logic                  coef_we = 1'b0;
    logic [CW-1:0]         coef_a = '0, coef_b = '0, coef_c = '0;
    logic                  out_valid;
    logic [LANES*OW-1:0]   out_data;

    fir_par_top #(.LANES(LANES), .DW(DW), .CW(CW), .OW(OW), .PIPE(PIPE)) u_dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .coef_we(coef_we), .coef_a(coef_a), .coef_b(coef_b), .coef_c(coef_c),
        .out_valid(out_valid), .out_data(out_data)
    );

    always #5 clk = ~clk;

    int checks = 0;
    int errors = 0;
    int sent = 0;
    int seen = 0;
    bit done = 1'b0;

    int m_ca = 0, m_cb = 0, m_cc = 0;
    int m_h1 = 0, m_h2 = 0;

    logic [LANES*OW-1:0] exp_q[$];
    string               tag_q[$];
    logic [LANES*OW-1:0] last_out = '0;

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic [LANES*OW-1:0] model(input int s0, input int s1, input int s2);
        int x[5];
        logic [LANES*OW-1:0] r;
        x[0] = m_h2; x[1] = m_h1; x[2] = s0; x[3] = s1; x[4] = s2;
        for (int k = 0; k < LANES; k++) begin
            int s;
            s = m_ca * x[k+2] + m_cb * x[k+1] + m_cc * x[k];
            r[k*OW +: OW] = OW'(s >>> SHIFT);
        end
        return r;
    endfunction

    task automatic put_block(input int s0, input int s1, input int s2, input string tag);
        in_valid = 1'b1;
        in_data  = {DW'(s2), DW'(s1), DW'(s0)};
        exp_q.push_back(model(s0, s1, s2));
        tag_q.push_back(tag);
        m_h2 = s1;
        m_h1 = s2;
        sent++;
    endtask

    task automatic send_block(input int s0, input int s1, input int s2, input string tag);
        @(negedge clk);
        coef_we = 1'b0;
        put_block(s0, s1, s2, tag);
    endtask

    task automatic set_coef(input int a, input int b, input int c);
        @(negedge clk);
        in_valid = 1'b0;
        coef_we  = 1'b1;
        coef_a = CW'(a); coef_b = CW'(b); coef_c = CW'(c);
        m_ca = a; m_cb = b; m_cc = c;
    endtask

    task automatic send_with_coef(input int s0, input int s1, input int s2,
                                  input int a, input int b, input int c, input string tag);
        @(negedge clk);
        coef_we = 1'b1;
        coef_a = CW'(a); coef_b = CW'(b); coef_c = CW'(c);
        put_block(s0, s1, s2, tag);
        m_ca = a; m_cb = b; m_cc = c;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            coef_we  = 1'b0;
        end
    endtask

    // Monitor: pops the scoreboard whenever a result block appears
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            seen++;
            if (exp_q.size() == 0) begin
                check(1'b0, "R5 unexpected output block", 1, 0);
            end else begin
                logic [LANES*OW-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                for (int k = 0; k < LANES; k++) begin
                    check(out_data[k*OW +: OW] == e[k*OW +: OW], $sformatf("%s lane %0d", t, k),
                          longint'($signed(out_data[k*OW +: OW])), longint'($signed(e[k*OW +: OW])));
                end
            end
            last_out = out_data;
        end
    end

    initial begin : main
        // R4: quiet outputs during reset
        repeat (3) @(negedge clk);
        check(out_valid == 1'b0, "R4 reset valid", longint'(out_valid), 0);
        check(out_data == '0, "R4 reset data", longint'(out_data), 0);
        rst_n = 1'b1;

        set_coef(3, -5, 7);
        // R4: first block sees zero history; R1 mapping
        send_block(10, 20, 30, "R4 R1 first block");
        // R2: back-to-back blocks carry history
        send_block(-4, 9, -100, "R2 carry");
        send_block(127, -128, 55, "R2 carry extreme");
        // R3: idle gap keeps history
        idle(4);
        send_block(1, 2, 3, "R3 after gap");

        // R8: hold while idle
        idle(LAT + 3);
        check(out_valid == 1'b0, "R8 idle valid", longint'(out_valid), 0);
        check(out_data == last_out, "R8 hold data", longint'(out_data), longint'(last_out));

        // R5: exact latency of a lone block
        send_block(-7, 8, -9, "R5 lone block");
        for (int i = 1; i <= LAT; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
            check(out_valid == (i == LAT), $sformatf("R5 valid at cycle %0d", i),
                  longint'(out_valid), longint'(i == LAT));
        end
        idle(2);

        // R6: write in the same cycle as a block; that block uses old set
        send_with_coef(11, -12, 13, 2, 1, -1, "R6 same-cycle write");
        send_block(5, 6, -7, "R6 new coefficients");
        idle(2);

        // R7: largest positive sum and floored negative
        set_coef(-128, -128, -128);
        send_block(-128, -128, -128, "R7 max sum");
        send_block(-128, -128, -128, "R7 max sum steady");
        set_coef(1, 0, 0);
        send_block(-1, -1, -1, "R7 floor of -1");
        send_block(64, -64, 63, "R7 exact shift");

        // R9: zero coefficients give zero output
        set_coef(0, 0, 0);
        send_block(100, -100, 77, "R9 zero coefficients");
        idle(LAT + 3);

        check(exp_q.size() == 0, "R5 all blocks returned", exp_q.size(), 0);
        check(seen == sent, "R5 output count", seen, sent);
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule